// File: doc/BRIEF.md
# Variable Refresh Vertical Timing Generator

The block produces the vertical timing of one display pipe whose frame length is not fixed. It counts lines on a line-rate tick, raises vertical blanking and vertical sync, and marks the first line of every frame. The end of each frame is decided at runtime. Once blanking begins, software may post a push request. The first line the block honours a pending push on starts the closing part of blanking, called the exit. The exit lasts a programmed number of lines, the guard. If no push arrives, the exit starts at the latest allowed line, so a frame never runs longer than its programmed maximum.

Software programs the line-count registers through a small write port and reads them back through a combinational read port. All timing registers are double-buffered. The values in use change only at the latch strobe, which fires on the line where the exit starts. The push register and the live status bit take effect at once. With variable refresh not live, the block runs fixed frames of the maximum length and does not act on pushes.

Top module: `vrr_vtiming_gen`

## Requirements
- R1: After reset the line count is 0 and vblank, vsync, frame_start, latch_strobe and vrr_live are all 0. The register reset values read back, the push register reads 0, and the control register reads with bit1 (minimum from flipline) set and bit0 clear.
- R2: The address map is 0 minimum, 1 maximum, 2 flipline, 3 guard, 4 sync-start offset, 5 sync-end offset, 6 control, 7 push. The line registers hold the wanted count minus one, and a read returns the last value written to that address.
- R3: While vrr_live is 0, every frame is maximum+1 lines long. A push posted then leaves the frame length unchanged and stays pending, so the push register reads 3.
- R4: The minimum total is flipline+1 when control bit1 is set, and minimum+1 otherwise. The earliest exit line is E = minimum total − g, where g is the guard. While vrr_live is 1, a push posted during line p starts the exit at line max(p+1, E), and the frame lasts that line + g lines.
- R5: While vrr_live is 1 and no push is pending, the exit starts at line maximum+1−g and the frame lasts maximum+1 lines.
- R6: The push register has bit0 enable and bit1 send. Send is set only by a write that also sets enable. While a push is pending the register reads 3. It reads back 1 once the exit start has consumed the send bit.
- R7: Writes to addresses 0–6 reach the timing only at latch_strobe. latch_strobe pulses once per frame, in the cycle after the tick that enters the exit line. The frame in progress keeps its old values.
- R8: Control bit0 enables variable refresh. vrr_live takes the latched enable value at the next frame start and changes at no other time. A read of the control register shows vrr_live in bit2.
- R9: line_count rises by one on each tick. On the tick after the last line of a frame it returns to 0, and frame_start pulses for one clock.
- R10: vblank is high from line E until the end of the frame.
- R11: vsync is high on lines L with T − start ≤ L < T − end, where T is the frame total and start and end are the sync offsets.
- R12: A guard value of 0 behaves as a guard of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | One-clock pulse per video line |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | LINE_W | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | LINE_W | Register read data (combinational) |
| line_count | output | LINE_W | Current line in the frame |
| vblank | output | 1 | Vertical blanking |
| vsync | output | 1 | Vertical sync |
| frame_start | output | 1 | One-clock pulse when a new frame begins |
| latch_strobe | output | 1 | One-clock pulse when programmed values take effect |
| vrr_live | output | 1 | Variable refresh is actually running |

## Verification
A wrong decision state or frame-end register shows at the ports within one frame. frame_start arrives on the wrong tick, and latch_strobe pulses on a line other than the predicted exit line. A wrong comparison in the window logic moves the vblank rising edge or the vsync lines, and the per-line checks catch this on the very line where it happens. A wrong live flag or push consume path changes the frame length of the next frame, or leaves the push register reading 3 after the exit.

// File: rtl/vrt_pkg.sv
package vrt_pkg;

   typedef enum logic [2:0] {
      A_VMIN     = 3'd0,
      A_VMAX     = 3'd1,
      A_FLIP     = 3'd2,
      A_GUARD    = 3'd3,
      A_VS_START = 3'd4,
      A_VS_END   = 3'd5,
      A_CTRL     = 3'd6,
      A_PUSH     = 3'd7
   } vrt_addr_e;

   localparam int unsigned NUM_LINE_REGS = 6;

   localparam int unsigned CTL_EN_BIT    = 0;
   localparam int unsigned CTL_FLIP_BIT  = 1;
   localparam int unsigned CTL_LIVE_BIT  = 2;

   localparam int unsigned PUSH_EN_BIT   = 0;
   localparam int unsigned PUSH_SEND_BIT = 1;

endpackage

// File: rtl/vrt_regfile.sv
module vrt_regfile
   import vrt_pkg::*;
#(
   parameter int unsigned      LINE_W       = 12,
   parameter logic [LINE_W-1:0] RST_VMIN     = LINE_W'(1079),
   parameter logic [LINE_W-1:0] RST_VMAX     = LINE_W'(1499),
   parameter logic [LINE_W-1:0] RST_FLIP     = LINE_W'(1124),
   parameter logic [LINE_W-1:0] RST_GUARD    = LINE_W'(40),
   parameter logic [LINE_W-1:0] RST_VS_START = LINE_W'(30),
   parameter logic [LINE_W-1:0] RST_VS_END   = LINE_W'(25),
   parameter bit                RST_FLIP_EN  = 1'b1
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic                                    wr_en,
   input  logic [2:0]                              wr_addr,
   input  logic [LINE_W-1:0]                       wr_data,
   input  logic [2:0]                              rd_addr,
   input  logic                                    latch,
   input  logic                                    consume,
   input  logic                                    live_in,
   output logic [LINE_W-1:0]                       rd_data,
   output logic [NUM_LINE_REGS-1:0][LINE_W-1:0]    act_line,
   output logic                                    act_en,
   output logic                                    act_flip_en,
   output logic                                    push_req
);

   localparam logic [NUM_LINE_REGS-1:0][LINE_W-1:0] RST_TBL =
      {RST_VS_END, RST_VS_START, RST_GUARD, RST_FLIP, RST_VMAX, RST_VMIN};

   logic [NUM_LINE_REGS-1:0][LINE_W-1:0] shadow_q;
   logic [NUM_LINE_REGS-1:0][LINE_W-1:0] active_q;
   logic ctl_en_sh, ctl_flip_sh;
   logic ctl_en_act, ctl_flip_act;
   logic push_en_q, push_send_q;

   // double-buffered line registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= RST_TBL;
         active_q <= RST_TBL;
      end else begin
         for (int i = 0; i < NUM_LINE_REGS; i++) begin
            if (wr_en && (wr_addr == 3'(i)))
               shadow_q[i] <= wr_data;
            if (latch)
               active_q[i] <= shadow_q[i];
         end
      end
   end

   // control word, double-buffered like the line registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_en_sh    <= 1'b0;
         ctl_flip_sh  <= RST_FLIP_EN;
         ctl_en_act   <= 1'b0;
         ctl_flip_act <= RST_FLIP_EN;
      end else begin
         if (wr_en && (wr_addr == A_CTRL)) begin
            ctl_en_sh   <= wr_data[CTL_EN_BIT];
            ctl_flip_sh <= wr_data[CTL_FLIP_BIT];
         end
         if (latch) begin
            ctl_en_act   <= ctl_en_sh;
            ctl_flip_act <= ctl_flip_sh;
         end
      end
   end

   // push register acts immediately; send needs enable in the same write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         push_en_q   <= 1'b0;
         push_send_q <= 1'b0;
      end else if (wr_en && (wr_addr == A_PUSH)) begin
         push_en_q   <= wr_data[PUSH_EN_BIT];
         push_send_q <= wr_data[PUSH_EN_BIT] & wr_data[PUSH_SEND_BIT];
      end else if (consume) begin
         push_send_q <= 1'b0;
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_VMIN     : rd_data = shadow_q[0];
         A_VMAX     : rd_data = shadow_q[1];
         A_FLIP     : rd_data = shadow_q[2];
         A_GUARD    : rd_data = shadow_q[3];
         A_VS_START : rd_data = shadow_q[4];
         A_VS_END   : rd_data = shadow_q[5];
         A_CTRL     : rd_data = {{(LINE_W-3){1'b0}}, live_in, ctl_flip_sh, ctl_en_sh};
         A_PUSH     : rd_data = {{(LINE_W-2){1'b0}}, push_send_q, push_en_q};
         default    : rd_data = '0;
      endcase
   end

   assign act_line    = active_q;
   assign act_en      = ctl_en_act;
   assign act_flip_en = ctl_flip_act;
   assign push_req    = push_send_q;

endmodule

// File: rtl/vrt_window.sv
module vrt_window #(
   parameter int unsigned LINE_W = 12,
   localparam int unsigned EW    = LINE_W + 1
) (
   input  logic [LINE_W-1:0] vmin_m1,
   input  logic [LINE_W-1:0] vmax_m1,
   input  logic [LINE_W-1:0] flip_m1,
   input  logic [LINE_W-1:0] guard,
   input  logic              flip_en,
   output logic [EW-1:0]     d_early,
   output logic [EW-1:0]     d_late,
   output logic [EW-1:0]     gap
);

   logic [EW-1:0] min_tot, max_tot, late_raw;

   always_comb begin
      min_tot  = (flip_en ? EW'(flip_m1) : EW'(vmin_m1)) + EW'(1);
      max_tot  = EW'(vmax_m1) + EW'(1);
      gap      = (guard == '0) ? EW'(1) : EW'(guard);
      d_early  = (min_tot > gap) ? (min_tot - gap) : EW'(1);
      late_raw = (max_tot > gap) ? (max_tot - gap) : EW'(1);
      d_late   = (late_raw > d_early) ? late_raw : d_early;
   end

endmodule

// File: rtl/vrt_seq.sv
module vrt_seq #(
   parameter int unsigned LINE_W = 12,
   localparam int unsigned EW    = LINE_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic [EW-1:0]     d_early,
   input  logic [EW-1:0]     d_late,
   input  logic [EW-1:0]     gap,
   input  logic              push_req,
   input  logic              en_act,
   output logic [LINE_W-1:0] lc,
   output logic              decided,
   output logic [EW-1:0]     frame_last,
   output logic              frame_start,
   output logic              latch_strobe,
   output logic              live,
   output logic              take
);

   logic [EW-1:0] next_line;
   logic          wrap;
   logic          decide_now;

   always_comb begin
      next_line  = EW'(lc) + EW'(1);
      wrap       = decided && (EW'(lc) == frame_last);
      decide_now = (next_line >= d_late) ||
                   (live && push_req && (next_line >= d_early));
      take       = line_tick && !wrap && !decided && decide_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lc           <= '0;
         decided      <= 1'b0;
         frame_last   <= '0;
         frame_start  <= 1'b0;
         latch_strobe <= 1'b0;
         live         <= 1'b0;
      end else begin
         frame_start  <= 1'b0;
         latch_strobe <= 1'b0;
         if (line_tick) begin
            if (wrap) begin
               lc          <= '0;
               decided     <= 1'b0;
               frame_start <= 1'b1;
               live        <= en_act;
            end else begin
               lc <= lc + LINE_W'(1);
               if (take) begin
                  decided      <= 1'b1;
                  frame_last   <= next_line + gap - EW'(1);
                  latch_strobe <= 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/vrt_vdec.sv
module vrt_vdec #(
   parameter int unsigned LINE_W = 12,
   localparam int unsigned EW    = LINE_W + 1,
   localparam int unsigned SW    = LINE_W + 2
) (
   input  logic [LINE_W-1:0] lc,
   input  logic              decided,
   input  logic [EW-1:0]     frame_last,
   input  logic [EW-1:0]     d_early,
   input  logic [LINE_W-1:0] vs_start,
   input  logic [LINE_W-1:0] vs_end,
   output logic              vblank,
   output logic              vsync
);

   logic [SW-1:0] total, lc_plus_s, lc_plus_e;

   always_comb begin
      total     = SW'(frame_last) + SW'(1);
      lc_plus_s = SW'(lc) + SW'(vs_start);
      lc_plus_e = SW'(lc) + SW'(vs_end);
      vblank    = decided || (EW'(lc) >= d_early);
      vsync     = decided && (lc_plus_s >= total) && (lc_plus_e < total);
   end

endmodule

// File: rtl/vrr_vtiming_gen.sv
module vrr_vtiming_gen
   import vrt_pkg::*;
#(
   parameter int unsigned      LINE_W       = 12,
   parameter logic [LINE_W-1:0] RST_VMIN     = LINE_W'(1079),
   parameter logic [LINE_W-1:0] RST_VMAX     = LINE_W'(1499),
   parameter logic [LINE_W-1:0] RST_FLIP     = LINE_W'(1124),
   parameter logic [LINE_W-1:0] RST_GUARD    = LINE_W'(40),
   parameter logic [LINE_W-1:0] RST_VS_START = LINE_W'(30),
   parameter logic [LINE_W-1:0] RST_VS_END   = LINE_W'(25),
   parameter bit                RST_FLIP_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_tick,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [LINE_W-1:0] wr_data,
   input  logic [2:0]        rd_addr,
   output logic [LINE_W-1:0] rd_data,
   output logic [LINE_W-1:0] line_count,
   output logic              vblank,
   output logic              vsync,
   output logic              frame_start,
   output logic              latch_strobe,
   output logic              vrr_live
);

   localparam int unsigned EW = LINE_W + 1;

   if (LINE_W < 4 || LINE_W > 16) begin : g_bad_width
      $error("vrr_vtiming_gen: LINE_W must lie in 4..16");
   end
   if (RST_GUARD > RST_VMAX) begin : g_bad_guard
      $error("vrr_vtiming_gen: reset guard exceeds reset maximum");
   end
   if (RST_VS_END > RST_VS_START) begin : g_bad_sync
      $error("vrr_vtiming_gen: reset sync end offset exceeds start offset");
   end

   logic [NUM_LINE_REGS-1:0][LINE_W-1:0] act_line;
   logic          act_en, act_flip_en, push_req;
   logic [EW-1:0] d_early, d_late, gap, frame_last;
   logic          decided, take, live;

   vrt_regfile #(
      .LINE_W(LINE_W), .RST_VMIN(RST_VMIN), .RST_VMAX(RST_VMAX),
      .RST_FLIP(RST_FLIP), .RST_GUARD(RST_GUARD),
      .RST_VS_START(RST_VS_START), .RST_VS_END(RST_VS_END),
      .RST_FLIP_EN(RST_FLIP_EN)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr),
      .latch(take), .consume(take & live), .live_in(live),
      .rd_data(rd_data), .act_line(act_line),
      .act_en(act_en), .act_flip_en(act_flip_en), .push_req(push_req)
   );

   vrt_window #(.LINE_W(LINE_W)) u_win (
      .vmin_m1(act_line[0]), .vmax_m1(act_line[1]),
      .flip_m1(act_line[2]), .guard(act_line[3]),
      .flip_en(act_flip_en),
      .d_early(d_early), .d_late(d_late), .gap(gap)
   );

   vrt_seq #(.LINE_W(LINE_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
      .d_early(d_early), .d_late(d_late), .gap(gap),
      .push_req(push_req), .en_act(act_en),
      .lc(line_count), .decided(decided), .frame_last(frame_last),
      .frame_start(frame_start), .latch_strobe(latch_strobe),
      .live(live), .take(take)
   );

   vrt_vdec #(.LINE_W(LINE_W)) u_dec (
      .lc(line_count), .decided(decided), .frame_last(frame_last),
      .d_early(d_early), .vs_start(act_line[4]), .vs_end(act_line[5]),
      .vblank(vblank), .vsync(vsync)
   );

   assign vrr_live = live;

endmodule

// File: rtl/vrr_vtiming_gen_chk.sv
module vrr_vtiming_gen_chk #(
   parameter int unsigned LINE_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              line_tick,
   input logic [LINE_W-1:0] line_count,
   input logic              vblank,
   input logic              vsync,
   input logic              frame_start,
   input logic              latch_strobe,
   input logic              vrr_live
);

   // R9: a new frame begins on line zero
   p_fs_line0_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |-> (line_count == '0));

   // R9: without a tick the line count holds
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !line_tick |=> $stable(line_count));

   // R9: frames are at least two lines, so frame_start never repeats back to back
   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> !frame_start);

   // R11: sync lies inside blanking
   p_sync_in_blank_r11: assert property (@(posedge clk) disable iff (!rst_n)
      vsync |-> vblank);

   // R7: latching happens at exit start, inside blanking
   p_latch_blank_r7: assert property (@(posedge clk) disable iff (!rst_n)
      latch_strobe |-> vblank);

   // R7: the latch line and the frame boundary never coincide
   p_latch_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(latch_strobe && frame_start));

   // R8: the live bit changes only at a frame start
   p_live_edge_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(vrr_live) || $fell(vrr_live)) |-> frame_start);

endmodule

bind vrr_vtiming_gen vrr_vtiming_gen_chk #(.LINE_W(LINE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .line_count(line_count),
   .vblank(vblank), .vsync(vsync), .frame_start(frame_start),
   .latch_strobe(latch_strobe), .vrr_live(vrr_live)
);

// File: tb/vrr_vtiming_gen_bench.sv
module vrr_vtiming_gen_bench;

   localparam int unsigned LW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          line_tick = 1'b0;
   logic          wr_en = 1'b0;
   logic [2:0]    wr_addr = '0;
   logic [LW-1:0] wr_data = '0;
   logic [2:0]    rd_addr = '0;
   logic [LW-1:0] rd_data, line_count;
   logic          vblank, vsync, frame_start, latch_strobe, vrr_live;

   int nvec = 0;
   int nerr = 0;
   bit fs_seen, ls_seen;

   always #5 clk = ~clk;

   vrr_vtiming_gen #(
      .LINE_W(LW), .RST_VMIN(8'd9), .RST_VMAX(8'd23), .RST_FLIP(8'd11),
      .RST_GUARD(8'd4), .RST_VS_START(8'd3), .RST_VS_END(8'd1), .RST_FLIP_EN(1'b1)
   ) u_vrr_vtiming_gen (
      .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .line_count(line_count),
      .vblank(vblank), .vsync(vsync), .frame_start(frame_start),
      .latch_strobe(latch_strobe), .vrr_live(vrr_live)
   );

   task automatic report();
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = LW'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output int v);
      rd_addr = 3'(a);
      #1;
      v = int'(rd_data);
   endtask

   task automatic tick();
      @(negedge clk);
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      fs_seen = frame_start;
      ls_seen = latch_strobe;
   endtask

   task automatic skip_frame();
      int n = 0;
      fs_seen = 1'b0;
      while (!fs_seen && n < 400) begin
         tick();
         n++;
      end
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // Runs one frame from line 0; posts a push during line p (p < 0: none).
   task automatic run_frame(input int p, input int exp_t, input int exp_d,
                            input int dmin, input int vss, input int vse,
                            input string req);
      int  ln = 0;
      int  v;
      bit  done = 1'b0;
      while (!done && ln < 400) begin
         chk(int'(line_count) == ln, "R9 line count", int'(line_count), ln);
         chk(vblank == (ln >= dmin), "R10 vblank", int'(vblank), int'(ln >= dmin));
         chk(vsync == ((ln >= exp_t - vss) && (ln < exp_t - vse)), "R11 vsync",
             int'(vsync), int'((ln >= exp_t - vss) && (ln < exp_t - vse)));
         if (ln == p) begin
            wr(7, 3);
            rd(7, v);
            chk(v == 3, "R6 pending push reads 3", v, 3);
         end
         tick();
         chk(ls_seen == (ln + 1 == exp_d), "R7 latch strobe line",
             int'(ls_seen), int'(ln + 1 == exp_d));
         done = fs_seen;
         ln++;
      end
      chk(ln == exp_t, {req, " frame length"}, ln, exp_t);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog expired");
      report();
   end

   initial begin
      int v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk(line_count == 0, "R1 line count", int'(line_count), 0);
      chk(!vblank && !vsync, "R1 vblank/vsync", int'({vblank, vsync}), 0);
      chk(!frame_start && !latch_strobe, "R1 pulses", int'({frame_start, latch_strobe}), 0);
      chk(!vrr_live, "R1 live", int'(vrr_live), 0);
      rd(1, v); chk(v == 23, "R1 maximum reset value", v, 23);
      rd(7, v); chk(v == 0, "R1 push reset", v, 0);
      rd(6, v); chk(v == 2, "R1 control reset", v, 2);

      // R2 readback of programmed value before it latches
      wr(0, 9);
      rd(0, v); chk(v == 9, "R2 minimum readback", v, 9);

      // R3 fixed frames, push ignored and left pending
      wr(7, 3);
      run_frame(-1, 24, 20, 8, 3, 1, "R3");
      rd(7, v); chk(v == 3, "R3 push still pending", v, 3);
      wr(7, 0);

      // R7 new maximum only after the latch strobe
      wr(1, 19);
      rd(1, v); chk(v == 19, "R2 maximum readback", v, 19);
      run_frame(-1, 24, 20, 8, 3, 1, "R7 old value kept");
      run_frame(-1, 20, 16, 8, 3, 1, "R7 new value used");
      wr(1, 23);
      run_frame(-1, 20, 16, 8, 3, 1, "R7 old value kept");
      run_frame(-1, 24, 20, 8, 3, 1, "R3");

      // R8 enable takes effect at a frame boundary
      wr(6, 3);
      chk(!vrr_live, "R8 live before boundary", int'(vrr_live), 0);
      run_frame(-1, 24, 20, 8, 3, 1, "R8");
      chk(vrr_live, "R8 live after boundary", int'(vrr_live), 1);
      rd(6, v); chk(v == 7, "R8 control readback with live", v, 7);

      // R4 sweep, flipline minimum, guard 4: E = 12-4 = 8
      for (int p = 0; p <= 19; p++) begin
         run_frame(p, imax(p + 1, 8) + 4, imax(p + 1, 8), 8, 3, 1, "R4");
         rd(7, v); chk(v == 1, "R6 send consumed", v, 1);
      end
      run_frame(-1, 24, 20, 8, 3, 1, "R5");

      // R6 send without enable is dropped
      wr(7, 2);
      rd(7, v); chk(v == 0, "R6 send without enable", v, 0);
      run_frame(-1, 24, 20, 8, 3, 1, "R6");

      // R4 sweep, minimum register, guard 2: E = 10-2 = 8, late line 22
      wr(6, 1); wr(3, 2); wr(4, 2); wr(5, 0);
      skip_frame();
      for (int p = 0; p <= 21; p++) begin
         wr(7, 1);
         run_frame(p, imax(p + 1, 8) + 2, imax(p + 1, 8), 8, 2, 0, "R4");
      end
      run_frame(-1, 24, 22, 8, 2, 0, "R5");

      // R12 guard 0 acts as 1: E = 12-1 = 11, late line 23
      wr(6, 3); wr(3, 0); wr(4, 1); wr(5, 0);
      skip_frame();
      for (int p = 0; p <= 22; p++) begin
         run_frame(p, imax(p + 1, 11) + 1, imax(p + 1, 11), 11, 1, 0, "R12");
      end

      // R8 disable drops live only at the frame boundary
      wr(6, 2);
      run_frame(-1, 24, 23, 11, 1, 0, "R5");
      chk(!vrr_live, "R8 live dropped at boundary", int'(vrr_live), 0);
      rd(6, v); chk(v == 2, "R8 control readback", v, 2);
      wr(7, 3);
      run_frame(-1, 24, 23, 11, 1, 0, "R3");
      rd(7, v); chk(v == 3, "R3 push ignored while not live", v, 3);

      report();
   end

endmodule